// File: doc/BRIEF.md
# Level/Pulse GPIO Output Generator

This block drives a small group of general-purpose output pins. Each pin is either a plain level output or a one-shot pulse output. Three byte-wide registers control it: a pin data register, a per-pin mode register, and a pulse-width register. They sit on a simple synchronous register bus with an address, a write strobe, write data and a combinational read-data path.

In level mode a pin copies its data bit. In pulse mode a pin idles low. Writing a 1 to its data bit fires a high pulse whose length is one of four real-time durations, by default 500 us, 1 ms, 20 ms or 100 ms. All pulse-mode pins share one width setting. A free-running prescaler divides the system clock down to a one-microsecond tick, and each pin counts those ticks until its pulse ends.

Top module: `gpio_pulse_out`

## Requirements
- R1: After reset, pin_out is 0 and every register reads back 0x00, so all pins start in level mode with width code 00.
- R2: Register map by address: 0 = pin data in bits 3:0 (bit n is pin n), 1 = mode in bits 3:0 (bit n is pin n, 0 = level, 1 = pulse), 2 = width code in bits 1:0. A write takes effect at the clock edge where reg_we is sampled high. reg_rdata shows the addressed register combinationally.
- R3: Unused bits (7:4 of data and mode, 7:2 of width) read 0 and ignore writes. Address 3 reads 0x00, and a write to it changes nothing.
- R4: A pin in level mode drives its data bit, updated in the cycle after the write edge.
- R5: A write to address 0 with bit n = 1 while pin n is already in pulse mode starts a pulse. The pin is high from the cycle after that write edge. A tick occurs every CLK_HZ/1,000,000 cycles, counted free-running from reset; the first tick comes in the last cycle of the first period. The pin falls after the clock edge that carries the N-th tick following the trigger, where N is the selected width in microseconds.
- R6: Width code 00/01/10/11 selects W0_US/W1_US/W2_US/W3_US microseconds (defaults 500, 1000, 20000, 100000). All pins share the code, and each pulse keeps the length latched when it fired.
- R7: A new trigger on a pin whose pulse is running reloads its count, so the pulse lasts a full N ticks from the new write.
- R8: Clearing a pin's mode bit cancels any running pulse. The pin drives its data bit from the next cycle, and returning to pulse mode does not resume the old pulse.
- R9: In pulse mode the pin is low when no pulse runs, whatever its data bit. Writing 0 to its data bit neither starts nor stops a pulse, and setting the mode bit alone never fires one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data of the addressed register (combinational) |
| pin_out | output | 4 | Output pins |

## Verification
Register reads are due in the same cycle the address is presented, so the bench drives the address on a falling edge and compares shortly after. Pin levels and pulse starts are due one cycle after the write edge. A pulse end falls on the edge after the N-th prescaler tick, so its cycle depends on the tick phase since reset. The bench keeps its own cycle-level model of the registers, the tick phase and each pin's remaining count, advances it on every rising edge from the same inputs, and compares the whole pin vector on every falling edge. Random register traffic with a fixed seed covers most cases, and directed sequences cover the width codes, retriggering, cancellation and the cases where the pin must stay low.

// File: rtl/gpo_pkg.sv
package gpo_pkg;

    localparam int REG_W = 8;

    typedef enum logic [1:0] {
        SEL_DATA  = 2'd0,
        SEL_MODE  = 2'd1,
        SEL_WIDTH = 2'd2,
        SEL_NONE  = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        WCODE_0 = 2'd0,
        WCODE_1 = 2'd1,
        WCODE_2 = 2'd2,
        WCODE_3 = 2'd3
    } width_code_e;

endpackage

// File: rtl/gpo_timebase.sv
module gpo_timebase #(
    parameter int CLK_HZ  = 50_000_000,
    parameter int TICK_HZ = 1_000_000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int DIV   = (CLK_HZ / TICK_HZ < 1) ? 1 : CLK_HZ / TICK_HZ;
    localparam int CNT_W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tb_state_t;

    tb_state_t s_d, s_q;

    assign tick_o = (s_q.cnt == LAST);

    always_comb begin
        s_d = s_q;
        if (tick_o) s_d.cnt = '0;
        else        s_d.cnt = s_q.cnt + CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    generate
        if (DIV > 1) begin : g_tick_chk
            // R5: ticks never land on two consecutive cycles when dividing
            a_r5_tick_isolated: assert property (@(posedge clk) disable iff (!rst_n)
                tick_o |=> !tick_o);
        end
    endgenerate

endmodule

// File: rtl/gpo_regfile.sv
module gpo_regfile
    import gpo_pkg::*;
#(
    parameter int N_PINS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [1:0]        addr_i,
    input  logic [REG_W-1:0]  wdata_i,
    output logic [REG_W-1:0]  rdata_o,
    output logic [N_PINS-1:0] data_o,
    output logic [N_PINS-1:0] mode_o,
    output logic [1:0]        width_o,
    output logic [N_PINS-1:0] fire_o
);
    typedef struct packed {
        logic [N_PINS-1:0] data;
        logic [N_PINS-1:0] mode;
        logic [1:0]        width;
    } rf_state_t;

    rf_state_t s_d, s_q;
    reg_sel_e  sel;

    assign sel = reg_sel_e'(addr_i);

    always_comb begin
        s_d = s_q;
        if (we_i) begin
            case (sel)
                SEL_DATA:  s_d.data  = wdata_i[N_PINS-1:0];
                SEL_MODE:  s_d.mode  = wdata_i[N_PINS-1:0];
                SEL_WIDTH: s_d.width = wdata_i[1:0];
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        case (sel)
            SEL_DATA:  rdata_o = REG_W'(s_q.data);
            SEL_MODE:  rdata_o = REG_W'(s_q.mode);
            SEL_WIDTH: rdata_o = REG_W'(s_q.width);
            default:   rdata_o = '0;
        endcase
    end

    // a trigger only counts for pins already in pulse mode
    assign fire_o  = (we_i && sel == SEL_DATA) ? (wdata_i[N_PINS-1:0] & s_q.mode) : '0;
    assign data_o  = s_q.data;
    assign mode_o  = s_q.mode;
    assign width_o = s_q.width;

    // R2: a mode write is visible on the following cycle
    a_r2_mode_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && sel == SEL_MODE) |=> (mode_o == $past(wdata_i[N_PINS-1:0])));

    // R3: reserved write bits never reach the read path
    a_r3_reserved_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && sel == SEL_MODE && wdata_i[REG_W-1:N_PINS] != '0)
            |=> (rdata_o[REG_W-1:N_PINS] == '0));

    // R3: writes to the unmapped address change no register
    a_r3_unmapped_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && sel == SEL_NONE) |=> ($stable(data_o) && $stable(mode_o) && $stable(width_o)));

endmodule

// File: rtl/gpo_pulse_chan.sv
module gpo_pulse_chan
    import gpo_pkg::*;
#(
    parameter int CNT_W = 17,
    parameter int LEN0  = 500,
    parameter int LEN1  = 1000,
    parameter int LEN2  = 20000,
    parameter int LEN3  = 100000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic       mode_i,
    input  logic       level_i,
    input  logic       fire_i,
    input  logic [1:0] width_i,
    output logic       pin_o
);
    typedef struct packed {
        logic [CNT_W-1:0] rem;
    } ch_state_t;

    ch_state_t        s_d, s_q;
    logic [CNT_W-1:0] load_len;
    logic             busy;

    always_comb begin
        case (width_code_e'(width_i))
            WCODE_0: load_len = CNT_W'(LEN0);
            WCODE_1: load_len = CNT_W'(LEN1);
            WCODE_2: load_len = CNT_W'(LEN2);
            default: load_len = CNT_W'(LEN3);
        endcase
    end

    assign busy = (s_q.rem != '0);

    always_comb begin
        s_d = s_q;
        if (!mode_i)                s_d.rem = '0;
        else if (fire_i)            s_d.rem = load_len;
        else if (tick_i && busy)    s_d.rem = s_q.rem - CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign pin_o = mode_i ? busy : level_i;

    // R5, R7: a trigger drives the pin high on the next cycle
    a_r7_fire_raises: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_i && mode_i) |=> pin_o);

    // R5: the remaining count only moves on a tick or a trigger
    a_r5_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i && !fire_i && !tick_i) |=> $stable(s_q.rem));

    // R8: leaving pulse mode drops any pending count
    a_r8_cancel_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_i) |=> !busy);

endmodule

// File: rtl/gpio_pulse_out.sv
module gpio_pulse_out
    import gpo_pkg::*;
#(
    parameter int CLK_HZ = 50_000_000,
    parameter int N_PINS = 4,
    parameter int W0_US  = 500,
    parameter int W1_US  = 1000,
    parameter int W2_US  = 20000,
    parameter int W3_US  = 100000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic [N_PINS-1:0] pin_out
);
    function automatic int max_of4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

    localparam int LEN_MAX = max_of4(W0_US, W1_US, W2_US, W3_US);
    localparam int CNT_W   = $clog2(LEN_MAX + 1);

    logic              tick;
    logic [N_PINS-1:0] data_bits;
    logic [N_PINS-1:0] mode_bits;
    logic [N_PINS-1:0] fire;
    logic [1:0]        width_code;

    gpo_timebase #(
        .CLK_HZ  (CLK_HZ),
        .TICK_HZ (1_000_000)
    ) i_timebase (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    gpo_regfile #(
        .N_PINS (N_PINS)
    ) i_regfile (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (reg_we),
        .addr_i  (reg_addr),
        .wdata_i (reg_wdata),
        .rdata_o (reg_rdata),
        .data_o  (data_bits),
        .mode_o  (mode_bits),
        .width_o (width_code),
        .fire_o  (fire)
    );

    generate
        for (genvar p = 0; p < N_PINS; p++) begin : g_pin
            gpo_pulse_chan #(
                .CNT_W (CNT_W),
                .LEN0  (W0_US),
                .LEN1  (W1_US),
                .LEN2  (W2_US),
                .LEN3  (W3_US)
            ) i_chan (
                .clk     (clk),
                .rst_n   (rst_n),
                .tick_i  (tick),
                .mode_i  (mode_bits[p]),
                .level_i (data_bits[p]),
                .fire_i  (fire[p]),
                .width_i (width_code),
                .pin_o   (pin_out[p])
            );
        end
    endgenerate

    // R9: setting mode bits alone never starts a pulse
    a_r9_mode_write_no_fire: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == SEL_MODE) |-> (fire == '0));

endmodule

// File: tb/test_gpio_pulse_out.sv
module test_gpio_pulse_out;
    localparam int CLK_PERIOD = 10;
    localparam int CLK_HZ     = 3_000_000;
    localparam int DIV        = 3;
    localparam int L0 = 4, L1 = 7, L2 = 12, L3 = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic [3:0] pin_out;

    int checks = 0;
    int failures = 0;
    bit mon_en = 1'b0;
    string cur_req = "R4";

    gpio_pulse_out #(
        .CLK_HZ (CLK_HZ), .N_PINS (4),
        .W0_US (L0), .W1_US (L1), .W2_US (L2), .W3_US (L3)
    ) i_gpio_pulse_out (
        .clk (clk), .rst_n (rst_n), .reg_we (reg_we), .reg_addr (reg_addr),
        .reg_wdata (reg_wdata), .reg_rdata (reg_rdata), .pin_out (pin_out)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // reference model of the requirements
    int         m_cnt;
    logic [3:0] m_data, m_mode;
    logic [1:0] m_width;
    int         m_rem [4];
    logic       m_tick;

    function automatic int len_of(input logic [1:0] code);
        case (code)
            2'd0: return L0;
            2'd1: return L1;
            2'd2: return L2;
            default: return L3;
        endcase
    endfunction

    function automatic logic [3:0] exp_pins();
        logic [3:0] v;
        for (int i = 0; i < 4; i++) v[i] = m_mode[i] ? (m_rem[i] != 0) : m_data[i];
        return v;
    endfunction

    function automatic logic [7:0] exp_read(input logic [1:0] a);
        case (a)
            2'd0: return {4'b0, m_data};
            2'd1: return {4'b0, m_mode};
            2'd2: return {6'b0, m_width};
            default: return 8'h00;
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cnt = 0; m_data = '0; m_mode = '0; m_width = '0;
            for (int i = 0; i < 4; i++) m_rem[i] = 0;
        end else begin
            m_tick = (m_cnt == DIV - 1);
            for (int i = 0; i < 4; i++) begin
                if (!m_mode[i]) m_rem[i] = 0;
                else if (reg_we && reg_addr == 2'd0 && reg_wdata[i]) m_rem[i] = len_of(m_width);
                else if (m_tick && m_rem[i] != 0) m_rem[i] = m_rem[i] - 1;
            end
            m_cnt = m_tick ? 0 : m_cnt + 1;
            if (reg_we) begin
                case (reg_addr)
                    2'd0: m_data  = reg_wdata[3:0];
                    2'd1: m_mode  = reg_wdata[3:0];
                    2'd2: m_width = reg_wdata[1:0];
                    default: ;
                endcase
            end
        end
    end

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%02h expected=0x%02h t=%0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle pin comparison against the model
    always @(negedge clk) begin
        if (rst_n && mon_en) check(cur_req, {4'b0, pin_out}, {4'b0, exp_pins()});
    end

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_check(input string tag, input logic [1:0] a, input logic [7:0] exp);
        @(negedge clk);
        reg_addr = a;
        #1;
        check(tag, reg_rdata, exp);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    // counts cycles the pin 0 output stays high, sampled at falling edges
    task automatic high_cycles(output int n);
        n = 0;
        while (pin_out[0] && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int n;
        void'($urandom(32'd2718));
        idle(3);
        #1 rst_n = 1'b1;

        // R1: reset state
        @(negedge clk);
        check("R1", {4'b0, pin_out}, 8'h00);
        for (int a = 0; a < 4; a++) rd_check("R1", 2'(a), 8'h00);
        mon_en = 1'b1;

        // R2, R3: register map, reserved bits, unmapped address
        cur_req = "R2";
        wr(2'd1, 8'hFF); rd_check("R3", 2'd1, 8'h0F);
        wr(2'd2, 8'hFF); rd_check("R3", 2'd2, 8'h03);
        wr(2'd1, 8'h00); wr(2'd2, 8'h00);
        wr(2'd0, 8'hA5); rd_check("R2", 2'd0, 8'h05);
        wr(2'd3, 8'hFF);
        rd_check("R3", 2'd3, 8'h00);
        rd_check("R3", 2'd0, 8'h05);
        rd_check("R3", 2'd1, 8'h00);

        // R4: level mode follows data one cycle after the write
        cur_req = "R4";
        wr(2'd0, 8'h09);
        check("R4", {4'b0, pin_out}, 8'h09);
        wr(2'd0, 8'h06);
        check("R4", {4'b0, pin_out}, 8'h06);
        wr(2'd0, 8'h00);

        // R5, R6: each width code on pin 0
        cur_req = "R6";
        wr(2'd1, 8'h01);
        for (int c = 0; c < 4; c++) begin
            wr(2'd2, 8'(c));
            wr(2'd0, 8'h01);
            check("R5", {7'b0, pin_out[0]}, 8'h01);
            high_cycles(n);
            check("R6", 8'((n >= (len_of(2'(c)) - 1) * DIV + 1) && (n <= len_of(2'(c)) * DIV)), 8'h01);
            idle(2);
        end

        // R7: retrigger restarts the count
        cur_req = "R7";
        wr(2'd2, 8'h01);
        wr(2'd0, 8'h01);
        idle(10);
        wr(2'd0, 8'h01);
        high_cycles(n);
        check("R7", 8'(n >= (L1 - 1) * DIV), 8'h01);
        idle(2);

        // R8: leaving pulse mode cancels and follows data at once
        cur_req = "R8";
        wr(2'd2, 8'h03);
        wr(2'd0, 8'h01);
        idle(3);
        wr(2'd1, 8'h00);
        check("R8", {7'b0, pin_out[0]}, 8'h01);
        wr(2'd1, 8'h01);
        check("R8", {7'b0, pin_out[0]}, 8'h00);

        // R9: idle low in pulse mode, zero writes inert, mode set alone does not fire
        cur_req = "R9";
        wr(2'd1, 8'h00);
        wr(2'd0, 8'h0F);
        wr(2'd1, 8'h0F);
        check("R9", {4'b0, pin_out}, 8'h00);
        wr(2'd0, 8'h02);
        idle(2);
        wr(2'd0, 8'h00);
        check("R9", {4'b0, pin_out}, 8'h02);
        idle(3 * L3 + 5);
        check("R9", {4'b0, pin_out}, 8'h00);

        // random register traffic against the model
        cur_req = "R5";
        for (int k = 0; k < 5000; k++) begin
            @(negedge clk);
            if ($urandom % 5 == 0) begin
                int r;
                r = $urandom % 8;
                reg_addr  = (r < 5) ? 2'd0 : 2'(r - 4);
                reg_wdata = 8'($urandom);
                reg_we    = 1'b1;
            end else begin
                reg_we   = 1'b0;
                reg_addr = 2'($urandom);
            end
            if (!reg_we) begin
                #1;
                check("R2", reg_rdata, exp_read(reg_addr));
            end
        end
        @(negedge clk);
        reg_we = 1'b0;
        idle(4);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule